// File: doc/BRIEF.md
# Sector erase sequencer with preprogram

This block is the erase engine that sits behind the command interface of a boot-sector flash array. A one-cycle start request brings either a chip-erase flag or a bitmask of sectors. The engine then handles the chosen sectors one at a time, lowest sector index first. For each sector it writes zero to every word, in ascending address order. It then repeats a timed erase pulse, and after every pulse it reads the sector back, until every word reads as all ones. If a sector is still not blank after the allowed number of pulses, the run stops and an error flag is raised.

The array has eleven sectors of unequal size. Measured in bytes of the full device, there are seven 64 KB sectors, one 32 KB sector, two 8 KB sectors and one 16 KB sector. A parameter places the small sectors at the low end or the high end of the address space. The engine reaches the array through a simple word port, which carries a write strobe, a read strobe with one cycle of latency, and an erase-pulse level together with the sector number it applies to. Word program time, pulse length and the pulse limit are all parameters.

Top module: `sector_erase_seq`

## Requirements
- R1: While reset is active and in the cycle after it, busy, done, error, memWe, memRe and eraseOn are all low.
- R2: A start sampled while idle raises busy from the next cycle. Busy stays high until the run completes. Completion is one cycle with done high and busy low, after which the block is idle. A start sampled while busy has no effect on the run.
- R3: The sectors are numbered 0 to 10 in ascending address order. With TOP_BOOT=0 their sizes in units are 2,1,1,4 followed by seven sectors of 8 units. With TOP_BOOT=1 the order of sizes is reversed. One unit is 2**ADDR_W/64 words.
- R4: Selected sectors are processed in ascending sector number. The contents of a sector that is not selected are never changed, and no access is made to it.
- R5: When chipErase is high at start, all eleven sectors are processed and sectorMask is ignored.
- R6: Before the first erase pulse on a sector, every word of that sector is written with data 0. The writes go in ascending address order, and memWe is held for WORD_CYCLES cycles on each address.
- R7: An erase pulse holds eraseOn for PULSE_CYCLES cycles, with eraseSector set to the current sector. The verify that follows reads words from the sector base upward. Each read is one memRe cycle, and the data is examined in the next cycle. The first word that is not all ones starts another pulse. When the last word reads all ones, the sector is done.
- R8: If a verify still fails after MAX_PULSES pulses on a sector, the run ends with the done cycle and error goes high. Error stays high until the next accepted start, which clears it.
- R9: A start with no sector selected and chipErase low gives one busy cycle followed by the done cycle.
- R10: Whenever the block writes, reads or pulses, memAddr lies inside the sector being processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a run |
| chipErase | input | 1 | Select all sectors for this run |
| sectorMask | input | 11 | One bit per sector, bit i is sector i |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Last run hit the pulse limit |
| memAddr | output | ADDR_W | Word address for program and verify |
| memWrData | output | DATA_W | Program data (always zero) |
| memWe | output | 1 | Program strobe |
| memRe | output | 1 | Read strobe, data returns next cycle |
| memRdData | input | DATA_W | Read data from the array |
| eraseOn | output | 1 | Erase pulse active |
| eraseSector | output | 4 | Sector that the pulse applies to |

## Verification
The hardest behaviour to reach is the pulse retry. A sector needs several pulses only if some word in it stays stubborn, and the error path needs a word that never clears within MAX_PULSES pulses. The bench memory model therefore keeps a pulse count for each word and a threshold per word that the bench sets. This lets it plant one slow word in the middle of a sector, which forces partial verifies followed by a retry, or one word that exceeds the limit. The reference model computes, ahead of each run, the exact cycle stream that follows from those thresholds.

// File: rtl/sector_erase_pkg.sv
package sector_erase_pkg;

  localparam int NUM_SECTORS = 11;
  localparam int SEC_W = $clog2(NUM_SECTORS);

  // size of a sector in units; the small ones sit low unless topBoot
  function automatic int unitSize(int idx, bit topBoot);
    int k;
    k = topBoot ? (NUM_SECTORS - 1 - idx) : idx;
    case (k)
      0: return 2;
      1, 2: return 1;
      3: return 4;
      default: return 8;
    endcase
  endfunction

  function automatic int unitBase(int idx, bit topBoot);
    int acc;
    acc = 0;
    for (int j = 0; j < NUM_SECTORS; j++)
      if (j < idx) acc += unitSize(j, topBoot);
    return acc;
  endfunction

  // address decoder: which sector holds a given unit
  function automatic int sectorOfUnit(int u, bit topBoot);
    int hit;
    hit = 0;
    for (int j = 0; j < NUM_SECTORS; j++)
      if (u >= unitBase(j, topBoot) && u < unitBase(j, topBoot) + unitSize(j, topBoot)) hit = j;
    return hit;
  endfunction

  typedef struct packed {
    logic loadMask;
    logic pick;
    logic addrInc;
    logic addrRewind;
    logic timerClr;
    logic pulseClr;
    logic pulseInc;
    logic setErr;
    logic access;
  } ctrl_strobe_t;

  typedef struct packed {
    logic maskEmpty;
    logic lastWord;
    logic wordTimeUp;
    logic pulseTimeUp;
    logic pulseLimit;
    logic readOnes;
  } dp_status_t;

endpackage

// File: rtl/sector_erase_dp.sv
module sector_erase_dp
  import sector_erase_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 16,
  parameter int WORD_CYCLES  = 8,
  parameter int PULSE_CYCLES = 1000000,
  parameter int MAX_PULSES   = 32,
  parameter bit TOP_BOOT     = 1'b0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrl_strobe_t           st,
  input  logic                   chipErase,
  input  logic [NUM_SECTORS-1:0] sectorMask,
  input  logic [DATA_W-1:0]      memRdData,
  output dp_status_t             stat,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [SEC_W-1:0]       curSector,
  output logic                   errFlag
);

  localparam int UNIT_WORDS = (2 ** ADDR_W) / 64;
  localparam int LONGEST    = (WORD_CYCLES > PULSE_CYCLES) ? WORD_CYCLES : PULSE_CYCLES;
  localparam int TIMER_W    = $clog2(LONGEST + 1);
  localparam int PCNT_W     = $clog2(MAX_PULSES + 1);

  logic [NUM_SECTORS-1:0] pending;
  logic [SEC_W-1:0]       curSec, nextSec, decodedSec;
  logic [ADDR_W-1:0]      addr;
  logic [TIMER_W-1:0]     timer;
  logic [PCNT_W-1:0]      pulseCnt;
  logic [ADDR_W-1:0]      secBase [NUM_SECTORS];
  logic [ADDR_W-1:0]      secLast [NUM_SECTORS];

  for (genvar i = 0; i < NUM_SECTORS; i++) begin : gen_map
    assign secBase[i] = ADDR_W'(unitBase(i, TOP_BOOT) * UNIT_WORDS);
    assign secLast[i] = ADDR_W'((unitBase(i, TOP_BOOT) + unitSize(i, TOP_BOOT)) * UNIT_WORDS - 1);
  end

  // lowest pending sector wins
  always_comb begin
    nextSec = '0;
    for (int i = NUM_SECTORS - 1; i >= 0; i--)
      if (pending[i]) nextSec = SEC_W'(i);
  end

  always_comb decodedSec = SEC_W'(sectorOfUnit(int'(addr) / UNIT_WORDS, TOP_BOOT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= '0;
      curSec   <= '0;
      addr     <= '0;
      timer    <= '0;
      pulseCnt <= '0;
      errFlag  <= 1'b0;
    end else begin
      if (st.loadMask) pending <= chipErase ? '1 : sectorMask;
      else if (st.pick) pending[nextSec] <= 1'b0;

      if (st.pick) curSec <= nextSec;

      if (st.pick) addr <= secBase[nextSec];
      else if (st.addrRewind) addr <= secBase[curSec];
      else if (st.addrInc) addr <= addr + 1'b1;

      timer <= st.timerClr ? '0 : timer + 1'b1;

      if (st.pulseClr) pulseCnt <= '0;
      else if (st.pulseInc) pulseCnt <= pulseCnt + 1'b1;

      if (st.loadMask) errFlag <= 1'b0;
      else if (st.setErr) errFlag <= 1'b1;
    end
  end

  always_comb begin
    stat.maskEmpty   = (pending == '0);
    stat.lastWord    = (addr == secLast[curSec]);
    stat.wordTimeUp  = (timer == TIMER_W'(WORD_CYCLES - 1));
    stat.pulseTimeUp = (timer == TIMER_W'(PULSE_CYCLES - 1));
    stat.pulseLimit  = (pulseCnt == PCNT_W'(MAX_PULSES));
    stat.readOnes    = &memRdData;
  end

  assign memAddr   = addr;
  assign curSector = curSec;

  a_r10_addr_in_sector: assert property (@(posedge clk) disable iff (!rstN)
    st.access |-> decodedSec == curSec);
  a_r4_pick_clears: assert property (@(posedge clk) disable iff (!rstN)
    st.pick |=> !pending[curSec]);
  a_r8_pulse_cap: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= PCNT_W'(MAX_PULSES));

endmodule

// File: rtl/sector_erase_ctrl.sv
module sector_erase_ctrl
  import sector_erase_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  dp_status_t   stat,
  output ctrl_strobe_t st,
  output logic         busy,
  output logic         done,
  output logic         memWe,
  output logic         memRe,
  output logic         eraseOn
);

  typedef enum logic [2:0] {
    S_IDLE, S_SELECT, S_PROG, S_ERASE, S_VREAD, S_VCHECK, S_FIN
  } phase_t;

  phase_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else state <= nxt;
  end

  always_comb begin
    st      = '0;
    nxt     = state;
    memWe   = 1'b0;
    memRe   = 1'b0;
    eraseOn = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        st.loadMask = 1'b1;
        nxt = S_SELECT;
      end
      S_SELECT: if (stat.maskEmpty) nxt = S_FIN;
      else begin
        st.pick = 1'b1;
        st.timerClr = 1'b1;
        st.pulseClr = 1'b1;
        nxt = S_PROG;
      end
      S_PROG: begin
        memWe = 1'b1;
        st.access = 1'b1;
        if (stat.wordTimeUp) begin
          st.timerClr = 1'b1;
          if (stat.lastWord) begin
            st.addrRewind = 1'b1;
            nxt = S_ERASE;
          end else st.addrInc = 1'b1;
        end
      end
      S_ERASE: begin
        eraseOn = 1'b1;
        st.access = 1'b1;
        if (stat.pulseTimeUp) begin
          st.pulseInc = 1'b1;
          nxt = S_VREAD;
        end
      end
      S_VREAD: begin
        memRe = 1'b1;
        st.access = 1'b1;
        nxt = S_VCHECK;
      end
      S_VCHECK: begin
        if (!stat.readOnes) begin
          if (stat.pulseLimit) begin
            st.setErr = 1'b1;
            nxt = S_FIN;
          end else begin
            st.addrRewind = 1'b1;
            st.timerClr = 1'b1;
            nxt = S_ERASE;
          end
        end else if (stat.lastWord) nxt = S_SELECT;
        else begin
          st.addrInc = 1'b1;
          nxt = S_VREAD;
        end
      end
      S_FIN: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE) && (state != S_FIN);
  assign done = (state == S_FIN);

  a_r2_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memWe, memRe, eraseOn}));
  a_r9_empty_ends: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SELECT && stat.maskEmpty) |=> done);
  a_r8_fail_ends: assert property (@(posedge clk) disable iff (!rstN)
    st.setErr |=> done);

endmodule

// File: rtl/sector_erase_seq.sv
module sector_erase_seq
  import sector_erase_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 16,
  parameter int WORD_CYCLES  = 8,
  parameter int PULSE_CYCLES = 1000000,
  parameter int MAX_PULSES   = 32,
  parameter bit TOP_BOOT     = 1'b0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic                   chipErase,
  input  logic [NUM_SECTORS-1:0] sectorMask,
  output logic                   busy,
  output logic                   done,
  output logic                   error,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [DATA_W-1:0]      memWrData,
  output logic                   memWe,
  output logic                   memRe,
  input  logic [DATA_W-1:0]      memRdData,
  output logic                   eraseOn,
  output logic [SEC_W-1:0]       eraseSector
);

  ctrl_strobe_t st;
  dp_status_t   stat;

  sector_erase_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stat(stat), .st(st),
    .busy(busy), .done(done), .memWe(memWe), .memRe(memRe), .eraseOn(eraseOn)
  );

  sector_erase_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_CYCLES(WORD_CYCLES),
    .PULSE_CYCLES(PULSE_CYCLES), .MAX_PULSES(MAX_PULSES), .TOP_BOOT(TOP_BOOT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .chipErase(chipErase), .sectorMask(sectorMask),
    .memRdData(memRdData), .stat(stat), .memAddr(memAddr), .curSector(eraseSector),
    .errFlag(error)
  );

  assign memWrData = '0;

endmodule

// File: tb/sector_erase_seq_bench.sv
`timescale 1ns/1ps
module sector_erase_seq_bench;

  localparam int AW = 7, DW = 16, WC = 2, PC = 3, MAXP = 4, NW = 128, NS = 11;

  typedef struct {
    bit busy; bit done; bit err; bit we; bit re; bit er; int addr; int sec;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN;
  logic chipV;
  logic [NS-1:0] maskV;
  logic startV [2];
  logic busyV [2], doneV [2], errV [2], weV [2], reV [2], erV [2];
  logic [AW-1:0] addrV [2];
  logic [DW-1:0] wdV [2], rdV [2];
  logic [3:0] secV [2];

  logic [DW-1:0] memA [2][NW];
  int needAbs [2][NW];
  int hits [2][NW];
  bit fillNow [2];
  bit prevEr [2];

  int compared = 0, mismatched = 0;
  exp_t expQ[$];

  for (genvar g = 0; g < 2; g++) begin : gen_dut
    sector_erase_seq #(
      .ADDR_W(AW), .DATA_W(DW), .WORD_CYCLES(WC), .PULSE_CYCLES(PC),
      .MAX_PULSES(MAXP), .TOP_BOOT(g == 1)
    ) u_sector_erase_seq (
      .clk(clk), .rstN(rstN), .start(startV[g]), .chipErase(chipV), .sectorMask(maskV),
      .busy(busyV[g]), .done(doneV[g]), .error(errV[g]), .memAddr(addrV[g]),
      .memWrData(wdV[g]), .memWe(weV[g]), .memRe(reV[g]), .memRdData(rdV[g]),
      .eraseOn(erV[g]), .eraseSector(secV[g])
    );
  end

  // sector geometry from the requirement text, in device kilobytes
  function automatic int kbOf(int s, bit top);
    int idx;
    idx = top ? NS - 1 - s : s;
    if (idx == 0) return 16;
    if (idx == 1 || idx == 2) return 8;
    if (idx == 3) return 32;
    return 64;
  endfunction
  function automatic int wordsOf(int s, bit top);
    return kbOf(s, top) * NW / 512;
  endfunction
  function automatic int baseOf(int s, bit top);
    int b;
    b = 0;
    for (int j = 0; j < s; j++) b += wordsOf(j, top);
    return b;
  endfunction
  function automatic logic [DW-1:0] pattern(int w);
    return DW'(32'h5A00 + w);
  endfunction

  // array model: per-word pulse count against a bench-set threshold
  always @(posedge clk) begin
    for (int g = 0; g < 2; g++) begin
      if (fillNow[g]) for (int w = 0; w < NW; w++) memA[g][w] = pattern(w);
      if (weV[g] === 1'b1) memA[g][addrV[g]] = wdV[g];
      if (erV[g] === 1'b1 && !prevEr[g]) begin
        for (int w = baseOf(int'(secV[g]), g == 1);
             w < baseOf(int'(secV[g]), g == 1) + wordsOf(int'(secV[g]), g == 1); w++) begin
          hits[g][w] = hits[g][w] + 1;
          if (hits[g][w] >= needAbs[g][w]) memA[g][w] = '1;
        end
      end
      prevEr[g] = (erV[g] === 1'b1);
      if (reV[g] === 1'b1) rdV[g] <= memA[g][addrV[g]];
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, expv, $time);
    end
  endtask

  function automatic exp_t mk(bit b, bit d, bit e, bit we, bit re, bit er, int a, int s);
    exp_t x;
    x.busy = b; x.done = d; x.err = e; x.we = we; x.re = re; x.er = er; x.addr = a; x.sec = s;
    return x;
  endfunction

  task automatic setNeeds(int g);
    for (int w = 0; w < NW; w++) needAbs[g][w] = hits[g][w] + 1;
  endtask

  task automatic buildExp(int g, bit chip, logic [NS-1:0] mask, output bit failed);
    bit top;
    int b, n, p, k, last;
    top = (g == 1);
    failed = 0;
    expQ.delete();
    expQ.push_back(mk(1, 0, 0, 0, 0, 0, 0, 0));
    for (int s = 0; s < NS; s++) begin
      if (!(chip || mask[s])) continue;
      b = baseOf(s, top);
      n = wordsOf(s, top);
      for (int w = b; w < b + n; w++)
        repeat (WC) expQ.push_back(mk(1, 0, 0, 1, 0, 0, w, s));
      p = 0;
      while (1) begin
        repeat (PC) expQ.push_back(mk(1, 0, 0, 0, 0, 1, b, s));
        p++;
        k = -1;
        for (int w = b; w < b + n; w++)
          if (needAbs[g][w] - hits[g][w] > p) begin k = w; break; end
        last = (k < 0) ? b + n - 1 : k;
        for (int w = b; w <= last; w++) begin
          expQ.push_back(mk(1, 0, 0, 0, 1, 0, w, s));
          expQ.push_back(mk(1, 0, 0, 0, 0, 0, w, s));
        end
        if (k < 0) break;
        if (p == MAXP) begin failed = 1; break; end
      end
      if (failed) break;
      expQ.push_back(mk(1, 0, 0, 0, 0, 0, 0, 0));
    end
    expQ.push_back(mk(0, 1, failed, 0, 0, 0, 0, 0));
  endtask

  task automatic runJob(int g, bit chip, logic [NS-1:0] mask, int poke, string tag);
    bit failed;
    exp_t e;
    int cyc;
    bit sel;
    buildExp(g, chip, mask, failed);
    fillNow[g] = 1;
    @(negedge clk);
    fillNow[g] = 0;
    chipV = chip;
    maskV = mask;
    startV[g] = 1;
    @(negedge clk);
    startV[g] = 0;
    cyc = 0;
    while (expQ.size() > 0) begin
      e = expQ.pop_front();
      chk(busyV[g] == e.busy, "R2", "busy", int'(busyV[g]), int'(e.busy));
      chk(doneV[g] == e.done, "R2", "done", int'(doneV[g]), int'(e.done));
      chk(errV[g] == e.err, "R8", "error", int'(errV[g]), int'(e.err));
      chk(weV[g] == e.we, "R6", "memWe", int'(weV[g]), int'(e.we));
      chk(reV[g] == e.re, "R7", "memRe", int'(reV[g]), int'(e.re));
      chk(erV[g] == e.er, "R7", "eraseOn", int'(erV[g]), int'(e.er));
      if (e.we) begin
        chk(int'(addrV[g]) == e.addr, "R3 R6", "program addr", int'(addrV[g]), e.addr);
        chk(wdV[g] == '0, "R6", "program data", int'(wdV[g]), 0);
      end
      if (e.re) chk(int'(addrV[g]) == e.addr, "R7 R10", "verify addr", int'(addrV[g]), e.addr);
      if (e.er) chk(int'(secV[g]) == e.sec, "R4 R7", "eraseSector", int'(secV[g]), e.sec);
      cyc++;
      if (cyc == poke) begin
        startV[g] = 1;
        chipV = 1;
        maskV = '1;
      end else startV[g] = 0;
      @(negedge clk);
    end
    startV[g] = 0;
    chk(busyV[g] == 0 && doneV[g] == 0, tag, "idle after done", int'(busyV[g]), 0);
    chk(errV[g] == failed, tag, "error held", int'(errV[g]), int'(failed));
    for (int s = 0; s < NS; s++) begin
      for (int w = baseOf(s, g == 1); w < baseOf(s, g == 1) + wordsOf(s, g == 1); w++) begin
        sel = chip || mask[s];
        if (!sel) chk(memA[g][w] == pattern(w), "R4", "untouched word", int'(memA[g][w]), int'(pattern(w)));
        else if (!failed) chk(memA[g][w] == '1, tag, "erased word", int'(memA[g][w]), 32'hFFFF);
      end
    end
  endtask

  initial begin
    rstN = 0;
    chipV = 0;
    maskV = '0;
    for (int g = 0; g < 2; g++) begin
      startV[g] = 0;
      fillNow[g] = 0;
      prevEr[g] = 0;
      for (int w = 0; w < NW; w++) hits[g][w] = 0;
      setNeeds(g);
    end
    repeat (3) @(negedge clk);
    for (int g = 0; g < 2; g++)
      chk(!busyV[g] && !doneV[g] && !errV[g] && !weV[g] && !reV[g] && !erV[g],
          "R1", "outputs in reset", int'({busyV[g], doneV[g], errV[g], weV[g], reV[g], erV[g]}), 0);
    rstN = 1;
    @(negedge clk);
    for (int g = 0; g < 2; g++)
      chk(!busyV[g] && !doneV[g] && !errV[g] && !weV[g] && !reV[g] && !erV[g],
          "R1", "outputs after reset", int'({busyV[g], doneV[g], errV[g], weV[g], reV[g], erV[g]}), 0);

    // single small sector, bottom boot
    runJob(0, 0, 11'b000_0000_0010, -1, "R4");
    // three sectors, one slow word forcing retries, stray start mid-run
    setNeeds(0);
    needAbs[0][baseOf(3, 0) + 5] += 2;
    runJob(0, 0, 11'b100_0000_1001, 20, "R2");
    // whole array, mask ignored
    setNeeds(0);
    runJob(0, 1, 11'b000_0000_0000, -1, "R5");
    // nothing selected
    runJob(0, 0, 11'b000_0000_0000, -1, "R9");
    // word that never blanks within the limit
    setNeeds(0);
    needAbs[0][baseOf(2, 0) + 1] = hits[0][baseOf(2, 0) + 1] + 6;
    runJob(0, 0, 11'b000_0000_0100, -1, "R8");
    // next start clears the error
    setNeeds(0);
    runJob(0, 0, 11'b000_0010_0000, -1, "R8");
    // top boot map
    setNeeds(1);
    needAbs[1][baseOf(9, 1)] += 1;
    runJob(1, 0, 11'b110_0000_0001, -1, "R3");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule